// File: doc/BRIEF.md
# Parallel EEPROM Access Sequencer

This block turns single-byte read and write requests into the pin-level sequence that an asynchronous parallel EEPROM with an 8-bit data bus expects. A requester presents an address, a direction flag and a write byte while the block is idle. The block then steps the address lines, the three active-low strobes (chip enable, output enable, write enable) and the drive enable of the shared data bus through a fixed order. Each step lasts a parameterised number of clock cycles. When the access is complete, the block returns the read byte together with a one-cycle completion pulse.

A write does not complete when the write strobe is released. The block keeps the array deselected for a programmable program-time count, which covers the cell programming delay of a fraction of a millisecond up to several milliseconds, and only then reports completion. A write-protect input turns write requests into immediate error completions that leave the bus untouched. Reads are not affected by write protect.

Top module: `pmem_bus_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, mem_ce_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0, rsp_done is 0 and req_ready is 1.
- R2: Read ordering. The address stays stable with chip enable high for T_AS cycles. mem_ce_n then falls, mem_oe_n falls exactly one cycle later, and mem_oe_n stays low for exactly T_ACC cycles.
- R3: Read return. rsp_rdata equals the value on mem_dq_in in the last cycle of the output-enable window. rsp_done is high for exactly one cycle, and it is set by the clock edge T_AS+T_ACC+2 edges after the accepting edge, with rsp_err 0.
- R4: Read release. mem_oe_n rises while mem_ce_n is still low, and mem_ce_n rises one cycle later. Chip enable never rises in a cycle in which output enable or write enable was low in the cycle before.
- R5: Write ordering. The address and the write byte (mem_dq_oe = 1) are held for T_AS cycles before mem_ce_n falls. mem_we_n falls one cycle after mem_ce_n and stays low for exactly T_WP cycles. For one more cycle after mem_we_n rises, mem_ce_n stays low and the data stays driven.
- R6: Program wait. After the hold cycle, the array is deselected and the bus is released for T_PROG cycles. rsp_done is then set by the edge T_AS+T_WP+T_PROG+2 edges after the accepting edge, with rsp_err 0. The written byte can be read back afterwards.
- R7: Bus exclusivity. mem_oe_n is never low while mem_dq_oe is 1 or while mem_we_n is low. Output enable and write enable are only ever low while mem_ce_n is low.
- R8: Turnaround. In the cycle before mem_oe_n falls, mem_dq_oe is 0 and mem_ce_n is low.
- R9: With wr_protect = 1, an accepted write completes on the next edge with rsp_done = 1 and rsp_err = 1. It produces no strobe or data-drive activity and does not change the array. Reads with wr_protect = 1 behave as in R2 and R3.
- R10: req_ready is 1 only while idle. A request held while req_ready is 0 is ignored and does not change the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; taken on an edge where req_ready is 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Byte to write |
| wr_protect | input | 1 | Rejects write requests when 1 |
| req_ready | output | 1 | Idle and able to accept a request |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Valid with rsp_done; 1 for a rejected write |
| rsp_rdata | output | DW | Read byte, valid with rsp_done of a read |
| mem_addr | output | AW | Memory address lines |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | DW | Byte driven onto the data bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus tri-state buffer |
| mem_dq_in | input | DW | Data bus as seen by the block |

## Verification
Every address of a small array is written with two different arithmetic byte patterns, one being the complement of the other, and read back after each pass. This shows that each address line and each data bit reaches the array and returns independently. A write followed immediately by a read of the same address exercises the turnaround from driving the bus to sampling it. It also separates the program-wait release from the start of the next read. Protected writes, both to addresses that hold a known pattern and during a read with write protect set, separate the reject path from the normal write path. Requests held while the block is busy show that such requests are never accepted late. A bus monitor measures every strobe window and the order of each edge against the timing parameters.

// File: rtl/pmem_seq_pkg.sv
package pmem_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_SETUP,
        ST_RD_CE,
        ST_RD_OE,
        ST_RD_END,
        ST_WR_SETUP,
        ST_WR_CE,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_WR_PROG
    } seq_state_e;

    // Pin-level controls; strobes are active low.
    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } bus_ctrl_t;

    localparam bus_ctrl_t BUS_QUIET = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

    // Pin levels that belong to each sequencer step.
    function automatic bus_ctrl_t ctrl_of(seq_state_e s);
        bus_ctrl_t c;
        c = BUS_QUIET;
        case (s)
            ST_RD_CE, ST_RD_END: c.ce_n = 1'b0;
            ST_RD_OE: begin
                c.ce_n = 1'b0;
                c.oe_n = 1'b0;
            end
            ST_WR_SETUP: c.dq_oe = 1'b1;
            ST_WR_CE, ST_WR_HOLD: begin
                c.ce_n  = 1'b0;
                c.dq_oe = 1'b1;
            end
            ST_WR_PULSE: begin
                c.ce_n  = 1'b0;
                c.we_n  = 1'b0;
                c.dq_oe = 1'b1;
            end
            default: c = BUS_QUIET;
        endcase
        return c;
    endfunction

    function automatic int max_of4(int a, int b, int c, int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    // Bits needed to hold a down-count starting at (span - 1).
    function automatic int count_bits(int span);
        return (span < 2) ? 1 : $clog2(span);
    endfunction

endpackage

// File: rtl/pmem_step_timer.sv
module pmem_step_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/pmem_seq_fsm.sv
module pmem_seq_fsm
    import pmem_seq_pkg::*;
#(
    parameter int T_AS   = 2,
    parameter int T_ACC  = 3,
    parameter int T_WP   = 2,
    parameter int T_PROG = 20000,
    parameter int CW     = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          wr_protect,
    input  logic          expired,
    output logic          load,
    output logic [CW-1:0] load_val,
    output logic          accept,
    output logic          reject,
    output logic          capture,
    output logic          finish,
    output logic          req_ready,
    output bus_ctrl_t     ctrl_q
);
    localparam logic [CW-1:0] LD_AS   = CW'(T_AS - 1);
    localparam logic [CW-1:0] LD_ACC  = CW'(T_ACC - 1);
    localparam logic [CW-1:0] LD_WP   = CW'(T_WP - 1);
    localparam logic [CW-1:0] LD_PROG = CW'(T_PROG - 1);
    localparam logic [CW-1:0] LD_ONE  = '0;

    seq_state_e st_q, st_nx;

    always_comb begin
        st_nx    = st_q;
        load     = 1'b0;
        load_val = LD_ONE;
        accept   = 1'b0;
        reject   = 1'b0;
        capture  = 1'b0;
        finish   = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_write && wr_protect) begin
                        reject = 1'b1;
                    end else begin
                        accept   = 1'b1;
                        load     = 1'b1;
                        load_val = LD_AS;
                        st_nx    = req_write ? ST_WR_SETUP : ST_RD_SETUP;
                    end
                end
            end
            ST_RD_SETUP: if (expired) begin
                st_nx = ST_RD_CE;
                load  = 1'b1;
            end
            ST_RD_CE: if (expired) begin
                st_nx    = ST_RD_OE;
                load     = 1'b1;
                load_val = LD_ACC;
            end
            ST_RD_OE: if (expired) begin
                capture = 1'b1;
                st_nx   = ST_RD_END;
                load    = 1'b1;
            end
            ST_RD_END: if (expired) begin
                finish = 1'b1;
                st_nx  = ST_IDLE;
            end
            ST_WR_SETUP: if (expired) begin
                st_nx = ST_WR_CE;
                load  = 1'b1;
            end
            ST_WR_CE: if (expired) begin
                st_nx    = ST_WR_PULSE;
                load     = 1'b1;
                load_val = LD_WP;
            end
            ST_WR_PULSE: if (expired) begin
                st_nx = ST_WR_HOLD;
                load  = 1'b1;
            end
            ST_WR_HOLD: if (expired) begin
                st_nx    = ST_WR_PROG;
                load     = 1'b1;
                load_val = LD_PROG;
            end
            ST_WR_PROG: if (expired) begin
                finish = 1'b1;
                st_nx  = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            ctrl_q <= BUS_QUIET;
        end else begin
            st_q   <= st_nx;
            ctrl_q <= ctrl_of(st_nx);
        end
    end

    assign req_ready = (st_q == ST_IDLE);
endmodule

// File: rtl/pmem_dq_path.sv
module pmem_dq_path #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          reject,
    input  logic          capture,
    input  logic          finish,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] dq_in,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] rdata_q,
    output logic          done_q,
    output logic          err_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture) begin
                rdata_q <= dq_in;
            end
            done_q <= finish | reject;
            err_q  <= reject;
        end
    end
endmodule

// File: rtl/pmem_bus_seq.sv
module pmem_bus_seq
    import pmem_seq_pkg::*;
#(
    parameter int AW     = 11,
    parameter int DW     = 8,
    parameter int T_AS   = 2,
    parameter int T_ACC  = 3,
    parameter int T_WP   = 2,
    parameter int T_PROG = 20000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          wr_protect,
    output logic          req_ready,
    output logic          rsp_done,
    output logic          rsp_err,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);
    localparam int LONGEST = max_of4(T_AS, T_ACC, T_WP, T_PROG);
    localparam int CW      = count_bits(LONGEST);

    logic          load, expired;
    logic [CW-1:0] load_val;
    logic          accept, reject, capture, finish;
    bus_ctrl_t     ctrl;

    pmem_step_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    pmem_seq_fsm #(
        .T_AS   (T_AS),
        .T_ACC  (T_ACC),
        .T_WP   (T_WP),
        .T_PROG (T_PROG),
        .CW     (CW)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .wr_protect (wr_protect),
        .expired    (expired),
        .load       (load),
        .load_val   (load_val),
        .accept     (accept),
        .reject     (reject),
        .capture    (capture),
        .finish     (finish),
        .req_ready  (req_ready),
        .ctrl_q     (ctrl)
    );

    pmem_dq_path #(.AW(AW), .DW(DW)) u_path (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .reject    (reject),
        .capture   (capture),
        .finish    (finish),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .dq_in     (mem_dq_in),
        .addr_q    (mem_addr),
        .wdata_q   (mem_dq_out),
        .rdata_q   (rsp_rdata),
        .done_q    (rsp_done),
        .err_q     (rsp_err)
    );

    assign mem_ce_n  = ctrl.ce_n;
    assign mem_oe_n  = ctrl.oe_n;
    assign mem_we_n  = ctrl.we_n;
    assign mem_dq_oe = ctrl.dq_oe;
endmodule

// File: rtl/pmem_bus_seq_chk.sv
module pmem_bus_seq_chk #(
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic          req_write,
    input logic          wr_protect,
    input logic          rsp_done,
    input logic          rsp_err,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ce_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic          mem_dq_oe
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_done)); // R1

    AST_ADDR_BEFORE_CE: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_ce_n) |-> $stable(mem_addr)); // R2

    AST_CE_RELEASE_LAST: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_ce_n) |-> ($past(mem_oe_n) && $past(mem_we_n))); // R4

    AST_WE_CONTEXT: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_ce_n && mem_dq_oe)); // R5

    AST_OE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (!mem_dq_oe && mem_we_n && !mem_ce_n)); // R7

    AST_OE_TURNAROUND: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_oe_n) |-> (!$past(mem_dq_oe) && !$past(mem_ce_n))); // R8

    AST_WP_REJECT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_write && wr_protect)
        |=> (rsp_done && rsp_err && mem_ce_n && !mem_dq_oe)); // R9

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        !mem_ce_n |-> !req_ready); // R10
endmodule

bind pmem_bus_seq pmem_bus_seq_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .wr_protect (wr_protect),
    .rsp_done   (rsp_done),
    .rsp_err    (rsp_err),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/tb_pmem_bus_seq.sv
module tb_pmem_bus_seq;
    localparam int AW = 4, DW = 8;
    localparam int T_AS = 2, T_ACC = 3, T_WP = 2, T_PROG = 6;
    localparam int DEPTH = 1 << AW;
    localparam int RD_LAT = T_AS + T_ACC + 3;          // negedges after accept
    localparam int WR_LAT = T_AS + T_WP + T_PROG + 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0, wr_protect = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_done, rsp_err;
    logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
    logic [AW-1:0] mem_addr;
    logic mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [DW-1:0] bmem [DEPTH];   // bus model of the array
    logic [DW-1:0] emem [DEPTH];   // expected contents
    int activity = 0;

    always #2.5 clk = ~clk;

    pmem_bus_seq #(.AW(AW), .DW(DW), .T_AS(T_AS), .T_ACC(T_ACC),
                   .T_WP(T_WP), .T_PROG(T_PROG)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .wr_protect(wr_protect),
        .req_ready(req_ready), .rsp_done(rsp_done), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    assign mem_dq_in = (!mem_ce_n && !mem_oe_n) ? bmem[mem_addr] : 8'hFF;

    always @(posedge clk)
        if (!mem_ce_n && !mem_we_n && mem_dq_oe) bmem[mem_addr] <= mem_dq_out;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Bus monitor: window lengths and edge order
    logic [AW-1:0] p_addr;
    logic p_ce, p_oe, p_we, p_dq;
    int arun = 0, drun = 0, olow = 0, wlow = 0;
    always @(negedge clk) begin
        if (!rst) begin
            arun = (mem_addr == p_addr) ? arun + 1 : 1;
            if (!mem_ce_n || mem_dq_oe) activity++;
            if (!mem_oe_n)
                check(mem_dq_oe == 0 && mem_we_n == 1 && mem_ce_n == 0, "R7", mem_dq_oe, 0);
            if (p_ce && !mem_ce_n) begin
                check(arun >= T_AS + 1, "R2 addr setup", arun, T_AS + 1);
                if (mem_dq_oe) check(drun + 1 == T_AS + 1, "R5 data setup", drun + 1, T_AS + 1);
            end
            if (p_oe && !mem_oe_n)
                check(!p_ce && !p_dq && arun >= T_AS + 2, "R8 turnaround", p_dq, 0);
            if (!p_oe && mem_oe_n)
                check(olow == T_ACC && !mem_ce_n, "R2 oe window", olow, T_ACC);
            if (!p_ce && mem_ce_n)
                check(p_oe && p_we, "R4 ce release", p_oe, 1);
            if (p_we && !mem_we_n)
                check(!p_ce, "R5 ce before we", p_ce, 0);
            if (!p_we && mem_we_n)
                check(wlow == T_WP && !mem_ce_n && mem_dq_oe, "R5 we pulse", wlow, T_WP);
            olow = mem_oe_n ? 0 : olow + 1;
            wlow = mem_we_n ? 0 : wlow + 1;
            drun = mem_dq_oe ? drun + 1 : 0;
        end
        p_addr = mem_addr; p_ce = mem_ce_n; p_oe = mem_oe_n;
        p_we = mem_we_n; p_dq = mem_dq_oe;
    end

    task automatic do_op(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic wp, output logic [DW-1:0] rd, output logic er,
                         output int lat);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; wr_protect = wp;
        check(req_ready == 1'b1, "R10 ready idle", req_ready, 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        while (!rsp_done && n < 200) begin
            @(negedge clk);
            n++;
        end
        lat = n; rd = rsp_rdata; er = rsp_err;
        @(negedge clk);
        check(rsp_done == 1'b0, "R3 done pulse", rsp_done, 0);
        wr_protect = 1'b0;
    endtask

    task automatic wr_chk(input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [DW-1:0] rd; logic er; int lat;
        do_op(1'b1, a, d, 1'b0, rd, er, lat);
        emem[a] = d;
        check(lat == WR_LAT && er == 0, "R6 write latency", lat, WR_LAT);
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input logic wp);
        logic [DW-1:0] rd; logic er; int lat;
        do_op(1'b0, a, 8'h00, wp, rd, er, lat);
        check(lat == RD_LAT && er == 0, "R3 read latency", lat, RD_LAT);
        check(rd == emem[a], "R3 read data", rd, emem[a]);
    endtask

    initial begin
        logic [DW-1:0] rd; logic er; int lat, act0;
        for (int i = 0; i < DEPTH; i++) begin bmem[i] = 8'h00; emem[i] = 8'h00; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_done, "R1 in reset", mem_ce_n, 1);
        rst = 1'b0;
        @(negedge clk);
        check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready, "R1 after reset", req_ready, 1);

        // Pass 1 and pass 2 (complement) over every address
        for (int p = 0; p < 2; p++) begin
            for (int a = 0; a < DEPTH; a++) begin
                logic [DW-1:0] v = 8'(a * 29 + 8'h13);
                wr_chk(AW'(a), p == 0 ? v : ~v);
            end
            for (int a = 0; a < DEPTH; a++) rd_chk(AW'(a), 1'b0);
        end

        // Write then immediate read: turnaround and program wait (R6, R8)
        for (int a = 0; a < DEPTH; a += 5) begin
            wr_chk(AW'(a), 8'(8'hA5 ^ a));
            rd_chk(AW'(a), 1'b0);
        end

        // Write protect: rejected writes, no bus activity, reads unaffected (R9)
        for (int a = 0; a < DEPTH; a += 3) begin
            act0 = activity;
            do_op(1'b1, AW'(a), 8'h3C, 1'b1, rd, er, lat);
            check(lat == 1 && er == 1, "R9 reject timing", lat, 1);
            check(activity == act0, "R9 no bus activity", activity - act0, 0);
            rd_chk(AW'(a), 1'b1);
        end

        // Request held while busy is ignored (R10)
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 4'd5;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 4'd9; req_wdata = 8'h5A;
        check(req_ready == 1'b0, "R10 busy not ready", req_ready, 0);
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_done) @(negedge clk);
        check(rsp_rdata == emem[5], "R3 read under busy", rsp_rdata, emem[5]);
        repeat (2) @(negedge clk);
        rd_chk(4'd9, 1'b0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule